// File: doc/BRIEF.md
# Reloadable Table Constant Multiplier

This block multiplies an 8-bit unsigned operand by an 8-bit unsigned constant without any array of AND-gate partial products. The operand is cut into two 4-bit nibbles. Each nibble indexes its own 16-entry table, and entry k of each table holds k times the constant as a 12-bit value. The table output for the upper nibble is moved up four bit positions and added to the table output for the lower nibble. The sum is the 16-bit product, which is registered and marked valid one cycle after the request.

To change the constant, the tables are rewritten. A load strobe captures a new constant. Over the next 16 cycles a sequencer writes k times the constant into entry k of both tables, and it builds each entry with one running addition per cycle. A busy flag is high during that window. Requests and further load strobes that arrive while it is high are dropped. Out of reset both tables hold zeros, which is the table set for constant 0.

Top module: `lutmul_top`

## Requirements
- R1: After reset, busy_o, prod_valid_o and prod_o are all zero, and until the first load every accepted request yields product 0.
- R2: A load_i pulse seen while busy_o is low is accepted. busy_o is high from the next cycle for exactly 16 cycles and then returns low.
- R3: A load_i pulse seen while busy_o is high is ignored, and the constant being loaded is kept.
- R4: A req_i seen while busy_o is high is ignored: prod_valid_o stays low in the next cycle and prod_o keeps its value.
- R5: A req_i in the same cycle as an accepted load_i is ignored: prod_valid_o stays low in the next cycle.
- R6: A req_i seen while busy_o and load_i are both low is accepted. In the next cycle prod_valid_o is 1 and prod_o equals operand_i times the constant of the last completed load, as an unsigned 16-bit value.
- R7: prod_valid_o is high only in the cycle after an accepted request. While prod_valid_o is low, prod_o holds its last value.
- R8: The product is the table entry for operand bits 3..0 placed at bits 11..0, plus the table entry for operand bits 7..4 placed at bits 15..4. The result is exact for all 256 operand values.
- R9: The extreme constants 0, 1 and 255 give exact products for every operand value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Strobe that starts a table reload with const_i |
| const_i | input | 8 | New constant, sampled with load_i |
| req_i | input | 1 | Multiply request |
| operand_i | input | 8 | Variable operand, sampled with req_i |
| busy_o | output | 1 | High while the tables are being rewritten |
| prod_valid_o | output | 1 | One-cycle pulse marking a new product |
| prod_o | output | 16 | Registered product |

## Verification
The hardest cases to reach are the ones inside the 16-cycle reload window. A second load pulse or a request that lands partway through the rewrite must leave no trace, yet a half-rewritten table mixes old and new constants.

The stimulus starts a reload and then waits a few cycles before injecting a request. It then sends a competing load with a different constant. Only after busy falls does it sweep all 256 operands against the first constant, so a leak from either intrusion shows up as a wrong product.

A separate scenario raises a request in the same cycle as the load strobe.

// File: rtl/lutmul_pkg.sv
package lutmul_pkg;
  // Width of one operand slice that addresses a table
  localparam int unsigned NIB_W = 4;
  // Entries per table follow from the slice width
  localparam int unsigned TAB_DEPTH = 1 << NIB_W;
endpackage

// File: rtl/lutmul_table.sv
module lutmul_table #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic              hit;
    logic [DATA_W-1:0] ent_d;

    assign hit = wr_en_i && (wr_addr_i == ADDR_W'(e));

    always_comb begin
      ent_d = mem_q[e];
      if (hit) ent_d = wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[e] <= '0;
      else if (hit) mem_q[e] <= ent_d;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/lutmul_loader.sv
module lutmul_loader #(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned CONST_W = 8,
  parameter int unsigned DATA_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [CONST_W-1:0] const_i,
  output logic               busy_o,
  output logic               wr_en_o,
  output logic [ADDR_W-1:0]  wr_addr_o,
  output logic [DATA_W-1:0]  wr_data_o
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  logic               busy_q, busy_d;
  logic [ADDR_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0]  acc_q, acc_d;
  logic [CONST_W-1:0] k_q, k_d;
  logic               start;

  assign start = load_i && !busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    k_d    = k_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      acc_d  = '0;
      k_d    = const_i;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      acc_d = acc_q + DATA_W'(k_q);
      if (cnt_q == LAST) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      acc_q  <= '0;
      k_q    <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      acc_q  <= acc_d;
      k_q    <= k_d;
    end
  end

  assign busy_o    = busy_q;
  assign wr_en_o   = busy_q;
  assign wr_addr_o = cnt_q;
  assign wr_data_o = acc_q;
endmodule

// File: rtl/lutmul_top.sv
module lutmul_top #(
  parameter int unsigned OPND_W  = 8,
  parameter int unsigned CONST_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_i,
  input  logic [CONST_W-1:0]         const_i,
  input  logic                       req_i,
  input  logic [OPND_W-1:0]          operand_i,
  output logic                       busy_o,
  output logic                       prod_valid_o,
  output logic [OPND_W+CONST_W-1:0]  prod_o
);
  import lutmul_pkg::*;

  localparam int unsigned NSLICE = OPND_W / NIB_W;
  localparam int unsigned PP_W   = NIB_W + CONST_W;
  localparam int unsigned PROD_W = OPND_W + CONST_W;

  logic              wr_en;
  logic [NIB_W-1:0]  wr_addr;
  logic [PP_W-1:0]   wr_data;
  logic [PP_W-1:0]   pp [NSLICE];
  logic [PROD_W-1:0] sum;
  logic              accept;

  logic              vld_q, vld_d;
  logic [PROD_W-1:0] prod_q, prod_d;

  lutmul_loader #(
    .ADDR_W (NIB_W),
    .CONST_W(CONST_W),
    .DATA_W (PP_W)
  ) u_loader (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_i),
    .const_i  (const_i),
    .busy_o   (busy_o),
    .wr_en_o  (wr_en),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data)
  );

  for (genvar g = 0; g < NSLICE; g++) begin : g_slice
    lutmul_table #(
      .ADDR_W(NIB_W),
      .DATA_W(PP_W)
    ) u_tab (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en_i  (wr_en),
      .wr_addr_i(wr_addr),
      .wr_data_i(wr_data),
      .rd_addr_i(operand_i[g*NIB_W +: NIB_W]),
      .rd_data_o(pp[g])
    );
  end

  always_comb begin
    sum = '0;
    for (int g = 0; g < NSLICE; g++) begin
      sum = sum + (PROD_W'(pp[g]) << (g * NIB_W));
    end
  end

  assign accept = req_i && !busy_o && !load_i;

  always_comb begin
    vld_d  = accept;
    prod_d = prod_q;
    if (accept) prod_d = sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      prod_q <= '0;
    end else begin
      vld_q  <= vld_d;
      prod_q <= prod_d;
    end
  end

  assign prod_valid_o = vld_q;
  assign prod_o       = prod_q;
endmodule

// File: rtl/lutmul_checker.sv
module lutmul_checker #(
  parameter int unsigned OPND_W  = 8,
  parameter int unsigned CONST_W = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      load_i,
  input logic [CONST_W-1:0]        const_i,
  input logic                      req_i,
  input logic [OPND_W-1:0]         operand_i,
  input logic                      busy_o,
  input logic                      prod_valid_o,
  input logic [OPND_W+CONST_W-1:0] prod_o
);
  localparam int unsigned PROD_W = OPND_W + CONST_W;
  localparam int unsigned DEPTH  = lutmul_pkg::TAB_DEPTH;
  localparam int unsigned LEN_W  = $clog2(DEPTH) + 2;

  logic [CONST_W-1:0] shadow_q;
  logic [LEN_W-1:0]   busy_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q   <= '0;
      busy_len_q <= '0;
    end else begin
      if (load_i && !busy_o) shadow_q <= const_i;
      if (busy_o) busy_len_q <= busy_len_q + 1'b1;
      else        busy_len_q <= '0;
    end
  end

  assert_load_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !busy_o) |=> busy_o);

  assert_busy_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (busy_len_q == LEN_W'(DEPTH)));

  assert_busy_blocks_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !prod_valid_o);

  assert_load_blocks_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !prod_valid_o);

  assert_product_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !busy_o && !load_i) |=>
      (prod_valid_o && prod_o == PROD_W'($past(operand_i)) * PROD_W'(shadow_q)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !prod_valid_o |-> $stable(prod_o));
endmodule

bind lutmul_top lutmul_checker #(
  .OPND_W (OPND_W),
  .CONST_W(CONST_W)
) u_lutmul_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_i      (load_i),
  .const_i     (const_i),
  .req_i       (req_i),
  .operand_i   (operand_i),
  .busy_o      (busy_o),
  .prod_valid_o(prod_valid_o),
  .prod_o      (prod_o)
);

// File: tb/lutmul_top_bench.sv
module lutmul_top_bench;
  logic        clk;
  logic        rst_n;
  logic        load_i;
  logic [7:0]  const_i;
  logic        req_i;
  logic [7:0]  operand_i;
  logic        busy_o;
  logic        prod_valid_o;
  logic [15:0] prod_o;

  int checks;
  int fails;
  int cycles;
  bit done;

  lutmul_top u_lutmul_top (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .const_i     (const_i),
    .req_i       (req_i),
    .operand_i   (operand_i),
    .busy_o      (busy_o),
    .prod_valid_o(prod_valid_o),
    .prod_o      (prod_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One accepted request, then check the pulse and the product
  task automatic mul_check(input string req, input logic [7:0] op, input int exp);
    @(negedge clk);
    req_i = 1'b1; operand_i = op;
    @(negedge clk);
    req_i = 1'b0;
    check({req, " valid"}, int'(prod_valid_o), 1);
    check({req, " product"}, int'(prod_o), exp);
  endtask

  task automatic sweep(input string req, input int k);
    for (int op = 0; op < 256; op++) mul_check(req, 8'(op), op * k);
  endtask

  // Load a constant and measure the busy window
  task automatic load_const(input logic [7:0] k);
    int len;
    @(negedge clk);
    load_i = 1'b1; const_i = k;
    @(negedge clk);
    load_i = 1'b0;
    len = 0;
    while (busy_o && len < 40) begin
      len++;
      @(negedge clk);
    end
    check("R2 busy length", len, 16);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; load_i = 1'b0; req_i = 1'b0; const_i = '0; operand_i = '0;
    repeat (3) @(negedge clk);
    check("R1 busy", int'(busy_o), 0);
    check("R1 valid", int'(prod_valid_o), 0);
    check("R1 prod", int'(prod_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    sweep("R1 zero tables", 0);
  endtask

  task automatic t_extremes;
    load_const(8'd0);   sweep("R9 const 0", 0);
    load_const(8'd1);   sweep("R9 const 1", 1);
    load_const(8'd255); sweep("R9 const 255", 255);
    load_const(8'd11);  sweep("R8 const 11", 11);
  endtask

  task automatic t_intrusions;
    logic [15:0] held;
    mul_check("R6 before reload", 8'd200, 200 * 11);
    held = prod_o;
    @(negedge clk);
    load_i = 1'b1; const_i = 8'd173;
    @(negedge clk);
    load_i = 1'b0;
    repeat (3) @(negedge clk);
    req_i = 1'b1; operand_i = 8'd77;
    @(negedge clk);
    req_i = 1'b0;
    check("R4 valid during busy", int'(prod_valid_o), 0);
    check("R4 prod held", int'(prod_o), int'(held));
    load_i = 1'b1; const_i = 8'd9;
    @(negedge clk);
    load_i = 1'b0;
    while (busy_o) @(negedge clk);
    check("R7 prod held", int'(prod_o), int'(held));
    sweep("R3 constant kept", 173);
  endtask

  task automatic t_same_cycle;
    logic [15:0] held;
    held = prod_o;
    @(negedge clk);
    load_i = 1'b1; const_i = 8'd58; req_i = 1'b1; operand_i = 8'd3;
    @(negedge clk);
    load_i = 1'b0; req_i = 1'b0;
    check("R5 valid", int'(prod_valid_o), 0);
    check("R5 prod held", int'(prod_o), int'(held));
    while (busy_o) @(negedge clk);
    mul_check("R6 after reload", 8'd255, 255 * 58);
    @(negedge clk);
    check("R7 single pulse", int'(prod_valid_o), 0);
    mul_check("R6 low nibble only", 8'h0F, 15 * 58);
    mul_check("R6 high nibble only", 8'hF0, 240 * 58);
  endtask

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    t_reset();
    t_extremes();
    t_intrusions();
    t_same_cycle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cycles = 0;
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule